// File: doc/BRIEF.md
# Wakeup and Reset Cause Status Register

This block is the 32-bit read-only cause register of a low-power supply controller. It records which events have woken the device or reset its core since software last looked. The events are a wakeup-pin event, a supply-monitor wakeup, a supply-monitor detection, a supply-monitor core reset, a rising edge of the brownout detector, and debouncer wakeups on two dedicated inputs. When the wakeup debouncer fires, the block also records which of up to 14 wakeup inputs were both enabled and active at that moment. Two further bits are not sticky. They show the present level of the supply monitor output and which oscillator drives the slow clock.

Software reads the register through a plain strobe port. The read data is a combinational view of the register, so the value seen in the strobe cycle is the value returned. At the clock edge that ends that cycle, every sticky flag clears, except a flag whose event arrives in that same cycle: that flag stays set. The debouncer, the oscillators and the analog monitors are outside the block and appear only as event pulses and levels on its inputs. No data stream passes through this block, so it has no valid/ready handshake. All pins are plain control and status signals.

Top module: `wake_status_reg`

## Requirements
- R1: After reset every bit of `rd_data` reads 0, provided `mon_below` and `xtal_sel` are 0.
- R2: Bits 0, 8 to 12, 15, 30 and 31 of `rd_data` always read 0. Bits 16+i for i ≥ NUM_WAKE also read 0.
- R3: A one-cycle pulse on an event input sets its flag at the next clock edge, and the flag holds until a read. The flag positions are `pin_wake_evt` at bit 1, `mon_wake_evt` at bit 2, `mon_reset_evt` at bit 4 and `mon_detect_evt` at bit 5.
- R4: In a cycle with `rd_strobe` high, `rd_data` shows the value before the clear. The sticky bits (1 to 5, 13, 14 and 16 to 29) read 0 from the next cycle on, unless a new event sets them.
- R5: An event that arrives in the same cycle as a read leaves its flag set after the read, because setting wins over clearing.
- R6: Bit 3 sets only on a rising edge of `brownout_lvl`. The input is registered once and then compared with its previous sample, so the flag appears two clock edges after the input rises. A level that stays high after a read does not set the flag again.
- R7: Bit 6 equals `mon_below` (1 means the supply is below threshold) and bit 7 equals `xtal_sel` (1 means crystal, 0 means RC). Both follow their inputs in the same cycle, and a read does not change them.
- R8: A pulse on `dbnc_pin_evt[0]` sets bit 13 and a pulse on `dbnc_pin_evt[1]` sets bit 14. Both are sticky and clear on read.
- R9: When `dbnc_fire` is high, bit 16+i is set for every input i with `wake_en[i]` and `wake_act[i]` both high. When `dbnc_fire` is low, `wake_en` and `wake_act` have no effect.
- R10: Snapshot bits from several debouncer firings are ORed together until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Read strobe; clears sticky flags at the end of the cycle |
| rd_data | output | 32 | Register contents |
| pin_wake_evt | input | 1 | Wakeup-pin event pulse |
| mon_wake_evt | input | 1 | Supply-monitor wakeup pulse |
| mon_reset_evt | input | 1 | Supply-monitor core reset pulse |
| mon_detect_evt | input | 1 | Supply-monitor detection pulse |
| brownout_lvl | input | 1 | Brownout detector output level |
| mon_below | input | 1 | Monitor result: 1 means below threshold |
| xtal_sel | input | 1 | Slow clock source: 1 means crystal |
| dbnc_pin_evt | input | 2 | Debouncer wakeup pulses for dedicated inputs 0 and 1 |
| dbnc_fire | input | 1 | Debouncer trigger pulse |
| wake_en | input | NUM_WAKE | Per-input wakeup enable |
| wake_act | input | NUM_WAKE | Per-input active level |

## Verification
The assertions take the event inputs to be synchronous to `clk`. They also take `brownout_lvl` to be sampled at the clock and not to glitch within a cycle, so that one detector edge produces exactly one registered edge. The stimulus keeps to this: the bench changes every input only at the falling clock edge and holds it for whole cycles. It drives `wake_en` and `wake_act` at any time, including cycles without `dbnc_fire`, so the snapshot checks show that these inputs are ignored unless the debouncer fires.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int REG_W     = 32;
  localparam int MAX_WAKE  = 14;
  localparam int POS_PIN   = 1;
  localparam int POS_MWAKE = 2;
  localparam int POS_BROWN = 3;
  localparam int POS_MRST  = 4;
  localparam int POS_MDET  = 5;
  localparam int POS_MLOW  = 6;
  localparam int POS_XTAL  = 7;
  localparam int POS_DB0   = 13;
  localparam int POS_DB1   = 14;
  localparam int POS_SNAP  = 16;

  typedef struct packed {
    logic db1;
    logic db0;
    logic mdet;
    logic mrst;
    logic brown;
    logic mwake;
    logic pin;
  } evt_t;

  localparam int NUM_EVT = $bits(evt_t);
endpackage

// File: rtl/wsr_sticky.sv
module wsr_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] kept;

  always_comb kept = clr ? '0 : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= kept | set;
  end

  // R5: any bit set in a cycle reads 1 afterwards, even under a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  // R4: a clear drops every bit not freshly set
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((q & ~$past(set)) == '0));
  // R3: without a clear no bit falls
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/wsr_rise.sv
module wsr_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic smp_q;
  logic smp_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q    <= 1'b0;
      smp_prev <= 1'b0;
    end else begin
      smp_q    <= lvl;
      smp_prev <= smp_q;
    end
  end

  assign rise = smp_q & ~smp_prev;

  // R6: an edge pulse lasts one cycle, so a held level yields no second event
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/wsr_capture.sv
module wsr_capture #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [N-1:0] en,
  input  logic [N-1:0] act,
  input  logic         clr,
  output logic [N-1:0] snap
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = fire & en[i] & act[i];
  end

  wsr_sticky #(.W(N)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit),
    .clr   (clr),
    .q     (snap)
  );

  // R10: without a read, earlier snapshot bits survive a later firing
  a_r10_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr) |=> ((snap & $past(snap)) == $past(snap)));
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg
  import wsr_pkg::*;
#(
  parameter int NUM_WAKE = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_strobe,
  output logic [31:0]         rd_data,
  input  logic                pin_wake_evt,
  input  logic                mon_wake_evt,
  input  logic                mon_reset_evt,
  input  logic                mon_detect_evt,
  input  logic                brownout_lvl,
  input  logic                mon_below,
  input  logic                xtal_sel,
  input  logic [1:0]          dbnc_pin_evt,
  input  logic                dbnc_fire,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic [NUM_WAKE-1:0] wake_act
);
  localparam int SNAP_W = (NUM_WAKE < MAX_WAKE) ? NUM_WAKE : MAX_WAKE;

  logic                brown_rise;
  evt_t                evt_in;
  evt_t                evt_q;
  logic [NUM_EVT-1:0]  evt_vec_q;
  logic [SNAP_W-1:0]   snap;

  wsr_rise u_brown (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (brownout_lvl),
    .rise  (brown_rise)
  );

  always_comb begin
    evt_in.pin   = pin_wake_evt;
    evt_in.mwake = mon_wake_evt;
    evt_in.brown = brown_rise;
    evt_in.mrst  = mon_reset_evt;
    evt_in.mdet  = mon_detect_evt;
    evt_in.db0   = dbnc_pin_evt[0];
    evt_in.db1   = dbnc_pin_evt[1];
  end

  wsr_sticky #(.W(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt_in),
    .clr   (rd_strobe),
    .q     (evt_vec_q)
  );

  assign evt_q = evt_t'(evt_vec_q);

  wsr_capture #(.N(SNAP_W)) u_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (dbnc_fire),
    .en    (wake_en[SNAP_W-1:0]),
    .act   (wake_act[SNAP_W-1:0]),
    .clr   (rd_strobe),
    .snap  (snap)
  );

  always_comb begin
    rd_data                     = '0;
    rd_data[POS_PIN]            = evt_q.pin;
    rd_data[POS_MWAKE]          = evt_q.mwake;
    rd_data[POS_BROWN]          = evt_q.brown;
    rd_data[POS_MRST]           = evt_q.mrst;
    rd_data[POS_MDET]           = evt_q.mdet;
    rd_data[POS_MLOW]           = mon_below;
    rd_data[POS_XTAL]           = xtal_sel;
    rd_data[POS_DB0]            = evt_q.db0;
    rd_data[POS_DB1]            = evt_q.db1;
    rd_data[POS_SNAP +: SNAP_W] = snap;
  end

  // R6: the brownout flag rises only after the detector was high two edges earlier
  a_r6_brown_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[POS_BROWN]) |-> $past(brownout_lvl, 2));
  // R9: a firing records every input that was enabled and active
  a_r9_snap_covers: assert property (@(posedge clk) disable iff (!rst_n)
    dbnc_fire |=> ((rd_data[POS_SNAP +: SNAP_W] & $past(wake_en[SNAP_W-1:0] & wake_act[SNAP_W-1:0]))
                   == $past(wake_en[SNAP_W-1:0] & wake_act[SNAP_W-1:0])));
  // R9: without a firing and with a read, no snapshot bit can be set next cycle
  a_r9_no_fire_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !dbnc_fire) |=> (rd_data[POS_SNAP +: SNAP_W] == '0));
  // R7: a read leaves the live bits following their inputs
  a_r7_live_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (rd_data[POS_MLOW] == mon_below && rd_data[POS_XTAL] == xtal_sel));
endmodule

// File: tb/wake_status_reg_test.sv
module wake_status_reg_test;
  localparam int NW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_strobe = 1'b0;
  logic [31:0]   rd_data;
  logic          pin_wake_evt = 1'b0, mon_wake_evt = 1'b0, mon_reset_evt = 1'b0;
  logic          mon_detect_evt = 1'b0, brownout_lvl = 1'b0;
  logic          mon_below = 1'b0, xtal_sel = 1'b0;
  logic [1:0]    dbnc_pin_evt = 2'b00;
  logic          dbnc_fire = 1'b0;
  logic [NW-1:0] wake_en = '0, wake_act = '0;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [31:0] m = '0;
  logic        bq = 1'b0, bp = 1'b0;

  localparam logic [31:0] RSV_MASK = 32'hC000_9F01;
  localparam logic [31:0] STICKY   = 32'h3FFF_603E;

  always #2 clk = ~clk;

  wake_status_reg #(.NUM_WAKE(NW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .pin_wake_evt(pin_wake_evt), .mon_wake_evt(mon_wake_evt),
    .mon_reset_evt(mon_reset_evt), .mon_detect_evt(mon_detect_evt),
    .brownout_lvl(brownout_lvl), .mon_below(mon_below), .xtal_sel(xtal_sel),
    .dbnc_pin_evt(dbnc_pin_evt), .dbnc_fire(dbnc_fire),
    .wake_en(wake_en), .wake_act(wake_act)
  );

  function automatic logic [31:0] expected();
    logic [31:0] e;
    e = m;
    e[6] = mon_below;
    e[7] = xtal_sel;
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge, drop pulses
  task automatic cyc(input string req);
    logic [31:0] s;
    @(posedge clk);
    s = '0;
    s[1]  = pin_wake_evt;
    s[2]  = mon_wake_evt;
    s[3]  = bq & ~bp;
    s[4]  = mon_reset_evt;
    s[5]  = mon_detect_evt;
    s[13] = dbnc_pin_evt[0];
    s[14] = dbnc_pin_evt[1];
    if (dbnc_fire) s[29:16] = wake_en & wake_act;
    if (!rst_n) m = '0;
    else if (rd_strobe) m = s;
    else m = m | s;
    if (!rst_n) begin bp = 1'b0; bq = 1'b0; end
    else begin bp = bq; bq = brownout_lvl; end
    @(negedge clk);
    chk(req, rd_data, expected());
    chk("R2", rd_data & RSV_MASK, 32'h0);
    pin_wake_evt = 0; mon_wake_evt = 0; mon_reset_evt = 0; mon_detect_evt = 0;
    dbnc_pin_evt = 2'b00; dbnc_fire = 0; rd_strobe = 0;
  endtask

  // read: value in the strobe cycle is the old one, clear lands at the edge
  task automatic rd(input string req);
    rd_strobe = 1'b1;
    #0.5;
    chk(req, rd_data, expected());
    cyc(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst_n = 1'b1;
    cyc("R1");
    chk("R1", rd_data, 32'h0);

    // R3: each plain event flag, sticky then cleared
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: pin_wake_evt = 1;
        1: mon_wake_evt = 1;
        2: mon_reset_evt = 1;
        default: mon_detect_evt = 1;
      endcase
      cyc("R3"); cyc("R3"); cyc("R3");
      rd("R4");
      chk("R4", rd_data & STICKY, 32'h0);
    end

    // R8: dedicated debouncer pins
    for (int k = 1; k < 4; k++) begin
      dbnc_pin_evt = k[1:0];
      cyc("R8"); cyc("R8");
      rd("R8");
      chk("R8", rd_data & STICKY, 32'h0);
    end

    // R6: brownout edge behaviour
    brownout_lvl = 1;
    cyc("R6");
    chk("R6", rd_data & 32'h8, 32'h0);
    cyc("R6");
    chk("R6", rd_data & 32'h8, 32'h8);
    rd("R6");
    for (int k = 0; k < 5; k++) cyc("R6");
    chk("R6", rd_data & 32'h8, 32'h0);
    brownout_lvl = 0; cyc("R6"); cyc("R6");
    brownout_lvl = 1; cyc("R6"); cyc("R6");
    chk("R6", rd_data & 32'h8, 32'h8);
    rd("R6");
    brownout_lvl = 0; cyc("R6"); cyc("R6");

    // R7: live bits under every combination, across reads
    for (int k = 0; k < 4; k++) begin
      mon_below = k[0]; xtal_sel = k[1];
      cyc("R7");
      chk("R7", rd_data & 32'hC0, {24'h0, k[1:0], 6'h0});
      rd("R7");
      chk("R7", rd_data & 32'hC0, {24'h0, k[1:0], 6'h0});
    end
    mon_below = 0; xtal_sel = 0;

    // R5: event during the read cycle survives
    pin_wake_evt = 1; cyc("R5");
    mon_detect_evt = 1; dbnc_fire = 1; wake_en = 14'h1; wake_act = 14'h1;
    rd("R5");
    chk("R5", rd_data & STICKY, 32'h0001_0020);
    rd("R5");

    // R9: per-input sweep of enable/active combinations
    for (int i = 0; i < NW; i++) begin
      for (int c = 0; c < 4; c++) begin
        wake_en = '0; wake_act = '0;
        wake_en[i] = c[0]; wake_act[i] = c[1];
        dbnc_fire = 1;
        cyc("R9");
        chk("R9", rd_data[29:16], (c == 3) ? (14'h1 << i) : 14'h0);
        rd("R9");
      end
    end
    // R9: no firing, inputs ignored
    wake_en = '1; wake_act = '1;
    cyc("R9"); cyc("R9");
    chk("R9", rd_data[29:16], 14'h0);

    // R10: accumulation over two firings
    wake_en = 14'h00FF; wake_act = 14'h0F0F; dbnc_fire = 1; cyc("R10");
    wake_en = 14'h3F00; wake_act = 14'h3300; dbnc_fire = 1; cyc("R10");
    chk("R10", rd_data[29:16], 14'h330F);
    rd("R10");
    chk("R10", rd_data[29:16], 14'h0);

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      pin_wake_evt   = ($urandom % 8) == 0;
      mon_wake_evt   = ($urandom % 8) == 0;
      mon_reset_evt  = ($urandom % 8) == 0;
      mon_detect_evt = ($urandom % 8) == 0;
      dbnc_pin_evt   = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      dbnc_fire      = ($urandom % 5) == 0;
      wake_en        = 14'($urandom);
      wake_act       = 14'($urandom);
      if (($urandom % 6) == 0) brownout_lvl = ~brownout_lvl;
      mon_below      = 1'($urandom);
      xtal_sel       = 1'($urandom);
      if (($urandom % 4) == 0) rd("R4");
      else cyc("R3");
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule